// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath of a 32-bit load/store processor that spreads each instruction over several clock cycles. One memory port serves both instruction fetch and data access. One ALU computes the PC increment, branch targets, effective addresses and arithmetic results. Staging registers hold each unit's output from one cycle to the next: the instruction register, the memory data register, the operand registers A and B, and the ALU result register.

An external sequencer drives every write enable, mux select and ALU operation code each cycle. It gets back the opcode field, the function field and the ALU zero flag. The memory behind the port returns read data in the same cycle as the address and captures write data at the clock edge. The datapath captures read data at the end of that cycle.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the PC, the instruction register, the memory data register, A, B, the ALU result register and every register-file entry to 0.
- R2: `mem_addr_o` is the PC when `addr_sel_i`=0 and the ALU result register when `addr_sel_i`=1. `mem_wdata_o` is register B. `mem_rd_o` and `mem_wr_o` follow `mem_rd_i` and `mem_wr_i` in the same cycle.
- R3: The instruction register loads `mem_rdata_i` at an edge only when `ir_wr_i`=1 and holds otherwise. `opcode_o` is its bits 31:26 and `funct_o` its bits 5:0.
- R4: The memory data register, A, B and the ALU result register load at every clock edge that is not in reset.
- R5: The first ALU operand is the PC when `alu_a_sel_i`=0 and register A when it is 1.
- R6: The second ALU operand is selected by `alu_b_sel_i`: 0 gives register B, 1 the constant 4, 2 the sign-extended instruction bits 15:0, and 3 that value shifted left by 2.
- R7: `alu_op_i` selects 0 add, 1 subtract (first minus second), 2 AND, 3 OR, 4 signed set-on-less-than (result 1 or 0). Codes 5 to 7 give 0. `zero_o` is 1 exactly when the ALU result is 0.
- R8: The PC is written at an edge when `pc_wr_i`=1, or when `pc_wr_cond_i`=1 and `zero_o`=1. Otherwise it holds.
- R9: The new PC value is selected by `pc_src_i`. A value of 0 or 3 gives the combinational ALU result. A value of 1 gives the ALU result register. A value of 2 gives the jump target: PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R10: A and B are read from the registers addressed by instruction bits 25:21 and 20:16. A write with `rf_wr_i`=1 goes to instruction bits 20:16 when `rf_dst_i`=0 and to bits 15:11 when it is 1. The written data is the ALU result register when `rf_src_i`=0 and the memory data register when it is 1.
- R11: Register 0 always reads as 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_wr_i | input | 1 | Instruction register load enable |
| pc_wr_i | input | 1 | Unconditional PC write |
| pc_wr_cond_i | input | 1 | PC write when the ALU result is zero |
| addr_sel_i | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd_i | input | 1 | Read strobe request from the sequencer |
| mem_wr_i | input | 1 | Write strobe request from the sequencer |
| rf_wr_i | input | 1 | Register file write enable |
| rf_dst_i | input | 1 | Write address field: 0 bits 20:16, 1 bits 15:11 |
| rf_src_i | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| alu_a_sel_i | input | 1 | First ALU operand: 0 PC, 1 A |
| alu_b_sel_i | input | 2 | Second ALU operand select |
| pc_src_i | input | 2 | Next PC source select |
| alu_op_i | input | 3 | ALU operation code |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data |
| opcode_o | output | 6 | Instruction bits 31:26 |
| funct_o | output | 6 | Instruction bits 5:0 |
| zero_o | output | 1 | ALU result equals zero |

## Verification
Assertions check four things on every cycle. The instruction register holds whenever its enable is low. The PC holds whenever neither write condition is met, and a jump keeps the PC's top four bits and clears its low two. The memory data register tracks the previous cycle's read data. A register-file write is visible on the next read of that address, and a subtract of equal operands raises the zero flag. Other behaviour can only be shown by bench scenarios that run sequences through the ports: the taken and untaken branch, the three PC sources, the destination and data selection of register writes, register 0 ignoring writes, and the full operand-mux and ALU-operation cross-product.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
   localparam int unsigned OPC_LSB  = 26;
   localparam int unsigned RS_LSB   = 21;
   localparam int unsigned RT_LSB   = 16;
   localparam int unsigned RD_LSB   = 11;
   localparam int unsigned IMM_W    = 16;
   localparam int unsigned JIDX_W   = 26;
   localparam int unsigned FIELD_W  = 6;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      BSEL_REG  = 2'd0,
      BSEL_FOUR = 2'd1,
      BSEL_IMM  = 2'd2,
      BSEL_IMM4 = 2'd3
   } bsel_e;

   typedef enum logic [1:0] {
      PCS_ALU    = 2'd0,
      PCS_ALUOUT = 2'd1,
      PCS_JUMP   = 2'd2,
      PCS_ALU2   = 2'd3
   } pcsrc_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
   import mc_dp_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [2:0]   op_i,
   output logic [W-1:0] res_o,
   output logic         zero_o
);
   always_comb begin
      case (alu_op_e'(op_i))
         ALU_ADD: res_o = a_i + b_i;
         ALU_SUB: res_o = a_i - b_i;
         ALU_AND: res_o = a_i & b_i;
         ALU_OR:  res_o = a_i | b_i;
         ALU_SLT: res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
         default: res_o = '0;
      endcase
   end

   assign zero_o = (res_o == '0);

   // R7: equal operands under subtract must report zero
   always_comb begin
      if (op_i == 3'd1 && a_i == b_i) begin
         p_sub_eq_zero_r7: assert (zero_o);
      end
   end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int unsigned W = 32,
   parameter int unsigned N = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we_i,
   input  logic [$clog2(N)-1:0] waddr_i,
   input  logic [W-1:0]         wdata_i,
   input  logic [$clog2(N)-1:0] raddr1_i,
   input  logic [$clog2(N)-1:0] raddr2_i,
   output logic [W-1:0]         rdata1_o,
   output logic [W-1:0]         rdata2_o
);
   localparam int unsigned AW = $clog2(N);

   logic [N*W-1:0] flat;

   for (genvar gi = 0; gi < N; gi++) begin : g_reg
      if (gi == 0) begin : g_zero
         assign flat[0 +: W] = '0;
      end else begin : g_flop
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we_i && waddr_i == AW'(gi))
               q <= wdata_i;
         end
         assign flat[gi*W +: W] = q;
      end
   end

   assign rdata1_o = flat[raddr1_i*W +: W];
   assign rdata2_o = flat[raddr2_i*W +: W];

   // R10: a write to a nonzero register is seen by the next read of it
   p_wr_lands_r10: assert property (@(posedge clk) disable iff (rst)
      (we_i && waddr_i != '0) |=>
      (raddr1_i != $past(waddr_i) || rdata1_o == $past(wdata_i)));
endmodule

// File: rtl/mc_pc_unit.sv
module mc_pc_unit
   import mc_dp_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic              wr_cond_i,
   input  logic              zero_i,
   input  logic [1:0]        src_i,
   input  logic [W-1:0]      alu_res_i,
   input  logic [W-1:0]      alu_out_i,
   input  logic [JIDX_W-1:0] jidx_i,
   output logic [W-1:0]      pc_o
);
   logic [W-1:0] pc_q, pc_next;
   logic         pc_en;

   assign pc_en = wr_i | (wr_cond_i & zero_i);

   always_comb begin
      case (pcsrc_e'(src_i))
         PCS_ALUOUT: pc_next = alu_out_i;
         PCS_JUMP:   pc_next = {pc_q[W-1 -: (W-JIDX_W-2)], jidx_i, 2'b00};
         default:    pc_next = alu_res_i;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else if (pc_en)
         pc_q <= pc_next;
   end

   assign pc_o = pc_q;

   // R8: with no write condition met the PC stays put
   p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(wr_i || (wr_cond_i && zero_i)) |=> (pc_q == $past(pc_q)));

   // R9: a jump keeps the top region bits and lands word aligned
   p_jump_region_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_i && src_i == 2'd2) |=>
      (pc_q[W-1 -: 4] == $past(pc_q[W-1 -: 4]) && pc_q[1:0] == 2'b00));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mc_dp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NREGS  = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ir_wr_i,
   input  logic              pc_wr_i,
   input  logic              pc_wr_cond_i,
   input  logic              addr_sel_i,
   input  logic              mem_rd_i,
   input  logic              mem_wr_i,
   input  logic              rf_wr_i,
   input  logic              rf_dst_i,
   input  logic              rf_src_i,
   input  logic              alu_a_sel_i,
   input  logic [1:0]        alu_b_sel_i,
   input  logic [1:0]        pc_src_i,
   input  logic [2:0]        alu_op_i,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [5:0]        opcode_o,
   output logic [5:0]        funct_o,
   output logic              zero_o
);
   localparam int unsigned RA_W = $clog2(NREGS);

   initial begin
      if (DATA_W != 32) $fatal(1, "mc_datapath: DATA_W must be 32 for the fixed field layout");
      if (NREGS != 32)  $fatal(1, "mc_datapath: NREGS must be 32 for 5-bit register fields");
   end

   logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
   logic [DATA_W-1:0] alu_a, alu_b, alu_res;
   logic [DATA_W-1:0] rf_rd1, rf_rd2, rf_wdata;
   logic [DATA_W-1:0] imm_ext, imm_x4;
   logic [RA_W-1:0]   rf_waddr;

   // staging registers: only the instruction register has an enable
   always_ff @(posedge clk) begin
      if (rst) begin
         ir_q     <= '0;
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         if (ir_wr_i) ir_q <= mem_rdata_i;
         mdr_q    <= mem_rdata_i;
         a_q      <= rf_rd1;
         b_q      <= rf_rd2;
         aluout_q <= alu_res;
      end
   end

   assign imm_ext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign imm_x4  = {imm_ext[DATA_W-3:0], 2'b00};

   assign alu_a = alu_a_sel_i ? a_q : pc_q;

   always_comb begin
      case (bsel_e'(alu_b_sel_i))
         BSEL_REG:  alu_b = b_q;
         BSEL_FOUR: alu_b = DATA_W'(4);
         BSEL_IMM:  alu_b = imm_ext;
         default:   alu_b = imm_x4;
      endcase
   end

   assign rf_waddr = rf_dst_i ? ir_q[RD_LSB +: RA_W] : ir_q[RT_LSB +: RA_W];
   assign rf_wdata = rf_src_i ? mdr_q : aluout_q;

   mc_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .we_i     (rf_wr_i),
      .waddr_i  (rf_waddr),
      .wdata_i  (rf_wdata),
      .raddr1_i (ir_q[RS_LSB +: RA_W]),
      .raddr2_i (ir_q[RT_LSB +: RA_W]),
      .rdata1_o (rf_rd1),
      .rdata2_o (rf_rd2)
   );

   mc_alu #(.W(DATA_W)) u_alu (
      .a_i    (alu_a),
      .b_i    (alu_b),
      .op_i   (alu_op_i),
      .res_o  (alu_res),
      .zero_o (zero_o)
   );

   mc_pc_unit #(.W(DATA_W)) u_pc (
      .clk       (clk),
      .rst       (rst),
      .wr_i      (pc_wr_i),
      .wr_cond_i (pc_wr_cond_i),
      .zero_i    (zero_o),
      .src_i     (pc_src_i),
      .alu_res_i (alu_res),
      .alu_out_i (aluout_q),
      .jidx_i    (ir_q[JIDX_W-1:0]),
      .pc_o      (pc_q)
   );

   assign mem_addr_o  = addr_sel_i ? aluout_q : pc_q;
   assign mem_wdata_o = b_q;
   assign mem_rd_o    = mem_rd_i;
   assign mem_wr_o    = mem_wr_i;
   assign opcode_o    = ir_q[OPC_LSB +: FIELD_W];
   assign funct_o     = ir_q[FIELD_W-1:0];

   // R3: the instruction register holds while its enable is low
   p_ir_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !ir_wr_i |=> $stable(ir_q));

   // R4: the memory data register tracks last cycle's read data
   p_mdr_capture_r4: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (mdr_q == $past(mem_rdata_i)));
endmodule

// File: tb/mc_datapath_tb_top.sv
module mc_datapath_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst;
   logic        ir_wr, pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr;
   logic        rf_wr, rf_dst, rf_src, alu_a_sel;
   logic [1:0]  alu_b_sel, pc_src;
   logic [2:0]  alu_op;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd_o, mem_wr_o, zero;
   logic [5:0]  opcode, funct;

   int checks = 0;
   int errors = 0;
   logic [31:0] pc_m;

   mc_datapath dut_i (
      .clk(clk), .rst(rst), .ir_wr_i(ir_wr), .pc_wr_i(pc_wr),
      .pc_wr_cond_i(pc_wr_cond), .addr_sel_i(addr_sel), .mem_rd_i(mem_rd),
      .mem_wr_i(mem_wr), .rf_wr_i(rf_wr), .rf_dst_i(rf_dst), .rf_src_i(rf_src),
      .alu_a_sel_i(alu_a_sel), .alu_b_sel_i(alu_b_sel), .pc_src_i(pc_src),
      .alu_op_i(alu_op), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_rdata_i(mem_rdata),
      .opcode_o(opcode), .funct_o(funct), .zero_o(zero)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] alu_m(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] bsel_m(input logic [1:0] s, input logic [31:0] b, input logic [15:0] imm);
      case (s)
         2'd0: return b;
         2'd1: return 32'd4;
         2'd2: return sext(imm);
         default: return {sext(imm)[29:0], 2'b00};
      endcase
   endfunction

   task automatic idle();
      ir_wr = 0; pc_wr = 0; pc_wr_cond = 0; addr_sel = 0; mem_rd = 0; mem_wr = 0;
      rf_wr = 0; rf_dst = 0; rf_src = 0; alu_a_sel = 0; alu_b_sel = 0; pc_src = 0; alu_op = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic load_ir(input logic [31:0] instr);
      mem_rdata = instr; ir_wr = 1; tick(); ir_wr = 0;
   endtask

   task automatic write_reg(input logic [4:0] k, input logic [31:0] val);
      load_ir({6'd0, 5'd0, 5'd0, k, 11'd0});
      mem_rdata = val; tick();
      rf_wr = 1; rf_src = 1; rf_dst = 1; tick();
      rf_wr = 0; rf_src = 0; rf_dst = 0;
   endtask

   task automatic read_b(input logic [4:0] k, output logic [31:0] v);
      load_ir({6'd0, 5'd0, k, 16'd0}); tick();
      v = mem_wdata;
   endtask

   task automatic read_a(input logic [4:0] k, output logic [31:0] v);
      load_ir({6'd0, k, 5'd0, 16'd0}); tick();
      alu_a_sel = 1; alu_b_sel = 2; alu_op = 0; tick();
      addr_sel = 1; #1; v = mem_addr; idle();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v, tgt, instr;
      void'($urandom(32'd1234));
      idle(); rst = 1; mem_rdata = 32'hFFFF_FFFF;
      tick(); tick(); rst = 0; pc_m = 0;

      // R1 reset state
      #1; chk("R1 pc", mem_addr, 32'd0);
      chk("R1 opcode", {26'd0, opcode}, 32'd0);
      chk("R1 funct", {26'd0, funct}, 32'd0);
      chk("R1 B", mem_wdata, 32'd0);
      addr_sel = 1; #1; chk("R1 aluout", mem_addr, 32'd0); idle();

      // fetch with PC+4 from raw ALU result
      instr = {6'h23, 5'd1, 5'd2, 16'h8A05};
      mem_rdata = instr; ir_wr = 1; mem_rd = 1; alu_b_sel = 1; pc_wr = 1; pc_src = 0;
      #1; chk("R2 rd strobe", {31'd0, mem_rd_o}, 32'd1);
      chk("R2 addr pc", mem_addr, pc_m);
      tick(); idle(); pc_m = pc_m + 4;
      #1; chk("R9 pc+4", mem_addr, pc_m);
      chk("R3 opcode", {26'd0, opcode}, 32'h23);
      chk("R3 funct", {26'd0, funct}, 32'h05);
      addr_sel = 1; #1; chk("R4 aluout", mem_addr, pc_m); idle();

      // R3 hold with enable low
      mem_rdata = 32'hFC00_003F; tick();
      chk("R3 hold opcode", {26'd0, opcode}, 32'h23);
      chk("R3 hold funct", {26'd0, funct}, 32'h05);

      // R10 / R4 write via MDR, read back through B and A, R2 write strobe
      write_reg(5'd12, 32'hCAFE_1234);
      read_b(5'd12, v); chk("R10 read B", v, 32'hCAFE_1234);
      mem_wr = 1; #1; chk("R2 wr strobe", {31'd0, mem_wr_o}, 32'd1);
      chk("R2 wdata is B", mem_wdata, 32'hCAFE_1234); idle();
      read_a(5'd12, v); chk("R10 read A", v, 32'hCAFE_1234);

      // R10 rt destination from ALU result register, rd untouched
      write_reg(5'd9, 32'h1234_5678);
      load_ir({6'h08, 5'd0, 5'd7, 5'd9, 11'h7F5}); tick();
      alu_a_sel = 1; alu_b_sel = 2; alu_op = 0; tick();
      rf_wr = 1; rf_dst = 0; rf_src = 0; tick(); idle();
      read_b(5'd7, v); chk("R10 rt dest", v, 32'h0000_4FF5);
      read_b(5'd9, v); chk("R10 rd untouched", v, 32'h1234_5678);

      // R11 register zero
      write_reg(5'd0, 32'hDEAD_BEEF);
      read_b(5'd0, v); chk("R11 r0 B", v, 32'd0);
      read_a(5'd0, v); chk("R11 r0 A", v, 32'd0);

      // R8 branch taken and not taken
      write_reg(5'd3, 32'h55); write_reg(5'd4, 32'h55); write_reg(5'd6, 32'h66);
      load_ir({6'h04, 5'd3, 5'd4, 16'h0010}); tick();
      alu_a_sel = 0; alu_b_sel = 3; alu_op = 0; tick();
      tgt = pc_m + 32'h40;
      alu_a_sel = 1; alu_b_sel = 0; alu_op = 1; pc_wr_cond = 1; pc_src = 1;
      #1; chk("R7 zero on equal", {31'd0, zero}, 32'd1);
      tick(); idle(); pc_m = tgt;
      #1; chk("R8 branch taken", mem_addr, pc_m);
      load_ir({6'h04, 5'd3, 5'd6, 16'h0010}); tick();
      alu_a_sel = 0; alu_b_sel = 3; alu_op = 0; tick();
      alu_a_sel = 1; alu_b_sel = 0; alu_op = 1; pc_wr_cond = 1; pc_src = 1;
      #1; chk("R7 zero low", {31'd0, zero}, 32'd0);
      tick(); idle();
      #1; chk("R8 branch not taken", mem_addr, pc_m);

      // R9 ALU result register source, jump, code 3
      write_reg(5'd5, 32'h7000_0010);
      load_ir({6'd0, 5'd5, 5'd0, 16'd0}); tick();
      alu_a_sel = 1; alu_b_sel = 2; alu_op = 0; tick();
      pc_wr = 1; pc_src = 1; tick(); idle(); pc_m = 32'h7000_0010;
      #1; chk("R9 aluout source", mem_addr, pc_m);
      load_ir({6'h02, 26'h0ABCDE});
      pc_wr = 1; pc_src = 2; tick(); idle();
      pc_m = {4'h7, 26'h0ABCDE, 2'b00};
      #1; chk("R9 jump", mem_addr, pc_m);
      pc_wr = 1; pc_src = 3; alu_a_sel = 0; alu_b_sel = 1; alu_op = 0; tick(); idle();
      pc_m = pc_m + 4;
      #1; chk("R9 code3", mem_addr, pc_m);

      // constrained random ALU / operand mux sweep (R5 R6 R7)
      for (int it = 0; it < 48; it++) begin
         logic [4:0]  rs, rt;
         logic [31:0] va, vb, ea, eb, er;
         logic [15:0] imm;
         logic [5:0]  opc;
         logic        asel;
         logic [1:0]  bs;
         logic [2:0]  op;
         rs  = 5'(1 + ($urandom % 31));
         rt  = 5'((rs % 31) + 1);
         va  = (it % 5 == 0) ? 32'h8000_0000 : $urandom;
         vb  = (it % 7 == 0) ? va : $urandom;
         imm = 16'($urandom);
         opc = 6'($urandom);
         asel = 1'($urandom);
         bs  = 2'($urandom);
         op  = 3'($urandom);
         write_reg(rs, va); write_reg(rt, vb);
         load_ir({opc, rs, rt, imm}); tick();
         alu_a_sel = asel; alu_b_sel = bs; alu_op = op;
         ea = asel ? va : pc_m;
         eb = bsel_m(bs, vb, imm);
         er = alu_m(op, ea, eb);
         #1; chk("R7 zero flag", {31'd0, zero}, {31'd0, er == 32'd0});
         tick();
         addr_sel = 1; #1; chk("R5 R6 R7 result", mem_addr, er);
         chk("R3 opcode rand", {26'd0, opcode}, {26'd0, opc});
         idle();
      end

      // R1 reset after activity
      rst = 1; tick(); rst = 0; pc_m = 0;
      #1; chk("R1 pc again", mem_addr, 32'd0);
      chk("R1 opcode again", {26'd0, opcode}, 32'd0);
      addr_sel = 1; #1; chk("R1 aluout again", mem_addr, 32'd0); idle();
      read_b(5'd5, v); chk("R1 regfile cleared", v, 32'd0);

      summary();
      $finish;
   end
endmodule